// File: doc/BRIEF.md
# Edge-Triggered Interrupt Input Unit

This block watches a group of external request lines and turns chosen transitions into latched request flags. Three lines are vectored sources. Line A has a software-chosen edge and an optional digital noise filter. Line B has a software-chosen edge and is never filtered. Line C reacts to every transition. The block also has two testable inputs that only latch a flag and never ask the processor for a vector. The first is a probe line that reacts to a rising edge. The second is a bank of key lines that share one flag, which is set when any of them falls.

Every pin passes through a two-flop synchroniser before edge detection. A flag stays set until software clears it with a masked write or until the interrupt controller acknowledges that source. The combined vector request is raised when at least one vectored flag is pending, its own enable is set and the master enable is set. Deciding which vector to serve, and fetching it, belong to the surrounding interrupt controller.

Top module: `irq_edge_unit`

## Requirements
- R1: Line C sets flag bit 2 on both rising and falling transitions.
- R2: Line A sets flag bit 0 on the edge chosen by `sel_a`. The encoding, shared with `sel_b`, is: 00 rising, 01 falling, 10 either edge, 11 no detection.
- R3: With `filt_en`=1, line A's level is accepted only after it has been stable for 3 consecutive samples. A pin change is then flagged on the 6th clock edge after it is applied, and a pulse of 2 clocks is rejected.
- R4: With `filt_en`=0, line A bypasses the filter. A pin change, including a one-clock pulse, is flagged on the 3rd clock edge after it is applied.
- R5: Line B sets flag bit 1 on the edge chosen by `sel_b`, with the same encoding as R2 and no filtering. With code 11 it never sets the flag.
- R6: The probe line sets flag bit 3 on a rising edge only and never raises `vreq_o`.
- R7: Any falling key line sets the shared flag bit 4. Rising key lines are ignored, and this flag never raises `vreq_o`.
- R8: `vreq_o` is registered and is high exactly when `master_en` is 1 and some vectored flag bit i (i = 0..2) is set with `src_en[i]`=1. It follows the flags with no extra clock.
- R9: A flag clears one clock after `clr_wr`=1 with its bit set in `clr_mask`, or after `ack_valid`=1 with `ack_id` equal to its bit index (0..2).
- R10: When a new edge and a clear for the same flag land on the same clock, the flag stays set.
- R11: Reset clears all flags, `vreq_o`, the synchronisers, the filter and the edge history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_a | input | 1 | Vectored line A, filterable, chosen edge |
| line_b | input | 1 | Vectored line B, chosen edge |
| line_c | input | 1 | Vectored line C, both edges |
| probe | input | 1 | Testable line, rising edge |
| keys | input | KEY_W | Testable key lines, falling edge |
| sel_a | input | 2 | Edge code for line A |
| sel_b | input | 2 | Edge code for line B |
| filt_en | input | 1 | 1 routes line A through the noise filter |
| src_en | input | 3 | Per-source vector enables (A, B, C) |
| master_en | input | 1 | Global vector enable |
| clr_wr | input | 1 | Masked clear strobe |
| clr_mask | input | 5 | Flags to clear |
| ack_valid | input | 1 | Vector acknowledge strobe |
| ack_id | input | 2 | Acknowledged source index |
| pend_o | output | 5 | Latched request flags |
| vreq_o | output | 1 | Combined vector request |

## Verification
A wrong edge history or synchroniser state shows up at `pend_o` as a missing or extra flag, three clocks after the pin moves, or six clocks when the filter is in use. A filter counter that is off by one shows up when a two-clock glitch is accepted, or when a real change is flagged one clock early or late. A fault in the enable gating or in the clear priority appears on `vreq_o` or `pend_o` on the very next clock. Checks are therefore timed to the exact edge, and the clock before the expected edge is also checked.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_sel_e;

  localparam int FLG_A     = 0;
  localparam int FLG_B     = 1;
  localparam int FLG_C     = 2;
  localparam int FLG_PROBE = 3;
  localparam int FLG_KEY   = 4;
  localparam int NUM_FLAGS = 5;
  localparam int NUM_VEC   = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/irq_noise_filter.sv
module irq_noise_filter #(
  parameter int STABLE = 3,
  parameter int DIV    = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(STABLE + 1);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          tick;
  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  generate
    if (DIV > 1) begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst)                        div_q <= '0;
        else if (div_q == DW'(DIV - 1)) div_q <= '0;
        else                            div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DW'(DIV - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (tick) begin
      if (din == lvl_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(STABLE - 1)) begin
        lvl_q <= din;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign dout = lvl_q;

  generate
    if (DIV == 1 && STABLE >= 2) begin : g_chk
      // R3: an accepted level was already present on the two previous samples
      assert_filter_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (lvl_q != $past(lvl_q)) |-> ($past(din) == lvl_q && $past(din, 2) == lvl_q));
    end
  endgenerate
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
  import irq_edge_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);
  logic hist_q;
  logic rise, fall;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= lvl_i;
  end

  assign rise = lvl_i & ~hist_q;
  assign fall = ~lvl_i & hist_q;

  always_comb begin
    case (sel_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] pend_nxt_o
);
  logic [N-1:0] pend_q;

  // a new edge outranks a clear of the same bit
  assign pend_nxt_o = (pend_q & ~clr_i) | set_i;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt_o;
  end

  assign pend_o = pend_q;

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_chk
      assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
        set_i[gi] |=> pend_q[gi]);
      assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_i[gi] && !set_i[gi]) |=> !pend_q[gi]);
    end
  endgenerate
endmodule

// File: rtl/irq_edge_unit.sv
module irq_edge_unit
  import irq_edge_pkg::*;
#(
  parameter int KEY_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_STABLE = 3,
  parameter int FILT_DIV    = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_a,
  input  logic             line_b,
  input  logic             line_c,
  input  logic             probe,
  input  logic [KEY_W-1:0] keys,
  input  logic [1:0]       sel_a,
  input  logic [1:0]       sel_b,
  input  logic             filt_en,
  input  logic [2:0]       src_en,
  input  logic             master_en,
  input  logic             clr_wr,
  input  logic [4:0]       clr_mask,
  input  logic             ack_valid,
  input  logic [1:0]       ack_id,
  output logic [4:0]       pend_o,
  output logic             vreq_o
);
  localparam int PINS = 4 + KEY_W;

  logic [PINS-1:0]      pins_s;
  logic                 a_s, b_s, c_s, probe_s;
  logic [KEY_W-1:0]     keys_s;
  logic                 a_filt, a_lvl;
  logic                 hit_a, hit_b, hit_c, hit_probe;
  logic [KEY_W-1:0]     hit_key;
  logic [NUM_FLAGS-1:0] set_v, clr_v, ack_v, pend_nxt, vec_mask;
  logic                 vreq_q;

  irq_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({keys, probe, line_c, line_b, line_a}),
    .q_o (pins_s)
  );

  assign a_s     = pins_s[0];
  assign b_s     = pins_s[1];
  assign c_s     = pins_s[2];
  assign probe_s = pins_s[3];
  assign keys_s  = pins_s[PINS-1:4];

  irq_noise_filter #(.STABLE(FILT_STABLE), .DIV(FILT_DIV)) u_filt (
    .clk  (clk),
    .rst  (rst),
    .din  (a_s),
    .dout (a_filt)
  );

  assign a_lvl = filt_en ? a_filt : a_s;

  irq_edge_det u_det_a (.clk(clk), .rst(rst), .lvl_i(a_lvl),   .sel_i(edge_sel_e'(sel_a)), .hit_o(hit_a));
  irq_edge_det u_det_b (.clk(clk), .rst(rst), .lvl_i(b_s),     .sel_i(edge_sel_e'(sel_b)), .hit_o(hit_b));
  irq_edge_det u_det_c (.clk(clk), .rst(rst), .lvl_i(c_s),     .sel_i(EDGE_BOTH),          .hit_o(hit_c));
  irq_edge_det u_det_p (.clk(clk), .rst(rst), .lvl_i(probe_s), .sel_i(EDGE_RISE),          .hit_o(hit_probe));

  generate
    for (genvar k = 0; k < KEY_W; k++) begin : g_key
      irq_edge_det u_det_k (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (keys_s[k]),
        .sel_i (EDGE_FALL),
        .hit_o (hit_key[k])
      );
    end
  endgenerate

  always_comb begin
    set_v            = '0;
    set_v[FLG_A]     = hit_a;
    set_v[FLG_B]     = hit_b;
    set_v[FLG_C]     = hit_c;
    set_v[FLG_PROBE] = hit_probe;
    set_v[FLG_KEY]   = |hit_key;
  end

  always_comb begin
    ack_v = '0;
    for (int i = 0; i < NUM_VEC; i++)
      if (ack_valid && ack_id == 2'(i)) ack_v[i] = 1'b1;
  end

  assign clr_v    = (clr_wr ? clr_mask : '0) | ack_v;
  assign vec_mask = {{(NUM_FLAGS-NUM_VEC){1'b0}}, src_en};

  irq_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .set_i      (set_v),
    .clr_i      (clr_v),
    .pend_o     (pend_o),
    .pend_nxt_o (pend_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) vreq_q <= 1'b0;
    else     vreq_q <= master_en & |(pend_nxt & vec_mask);
  end

  assign vreq_o = vreq_q;

  assert_master_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> !vreq_o);
  assert_test_no_vec_R6: assert property (@(posedge clk) disable iff (rst)
    vreq_o |-> (|pend_o[NUM_VEC-1:0]));
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (pend_o == '0 && !vreq_o));
endmodule

// File: tb/tb_irq_edge_unit.sv
`timescale 1ns/1ps
module tb_irq_edge_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_a = 0, line_b = 0, line_c = 0, probe = 0;
  logic [7:0] keys = 8'hFF;
  logic [1:0] sel_a = 0, sel_b = 0;
  logic       filt_en = 0, master_en = 0, clr_wr = 0, ack_valid = 0;
  logic [2:0] src_en = 0;
  logic [4:0] clr_mask = 0;
  logic [1:0] ack_id = 0;
  logic [4:0] pend_o;
  logic       vreq_o;

  irq_edge_unit dut (.*);

  always #2.5 clk = ~clk;

  typedef struct {int due; logic [4:0] pend; logic vreq; string tag;} exp_t;
  exp_t q[$];
  int   cyc = 0, checks = 0, errors = 0;
  logic [4:0] ep = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic calc_vreq();
    return master_en & |(ep[2:0] & src_en);
  endfunction

  task automatic push(int d, string tag);
    exp_t e;
    e.due = cyc + d; e.pend = ep; e.vreq = calc_vreq(); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go(int d, string tag);
    push(d, tag);
    waitn(d + 1);
  endtask

  task automatic clear(logic [4:0] m, string tag);
    clr_wr = 1; clr_mask = m; ep &= ~m;
    push(1, tag);
    waitn(1);
    clr_wr = 0; clr_mask = 0;
    waitn(1);
  endtask

  task automatic ack(logic [1:0] id, string tag);
    ack_valid = 1; ack_id = id; ep[id] = 1'b0;
    push(1, tag);
    waitn(1);
    ack_valid = 0;
    waitn(1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pend_o !== e.pend || vreq_o !== e.vreq) begin
        errors++;
        $display("FAIL %s: pend=%b vreq=%b expected pend=%b vreq=%b",
                 e.tag, pend_o, vreq_o, e.pend, e.vreq);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    waitn(3);
    rst = 0;
    waitn(4);
    go(1, "R11 reset state");
    master_en = 1; src_en = 3'b111;

    // R1: both edges on line C
    line_c = 1; ep[2] = 1; go(3, "R1 rise");
    clear(5'b00100, "R9 masked clear");
    line_c = 0; ep[2] = 1; go(3, "R1 fall");
    ack(2, "R9 ack C");

    // R5: line B edge codes
    sel_b = 2'b00; line_b = 1; ep[1] = 1; go(3, "R5 rise code");
    clear(5'b00010, "R9 clear B");
    line_b = 0; go(3, "R5 fall ignored under rise code");
    sel_b = 2'b01; line_b = 1; go(3, "R5 rise ignored under fall code");
    line_b = 0; ep[1] = 1; go(3, "R5 fall code");
    clear(5'b00010, "R9 clear B");
    sel_b = 2'b11; line_b = 1; go(3, "R5 none code rise");
    line_b = 0; go(3, "R5 none code fall");
    sel_b = 2'b10; line_b = 1; ep[1] = 1; go(3, "R5 both code rise");
    clear(5'b00010, "R9 clear B");
    line_b = 0; ep[1] = 1; go(3, "R5 both code fall");
    ack(1, "R9 ack B");

    // R8: gating
    master_en = 0; line_c = 1; ep[2] = 1; go(3, "R8 master off");
    master_en = 1; go(1, "R8 master on");
    src_en = 3'b011; go(1, "R8 source disabled");
    src_en = 3'b111; go(1, "R8 source re-enabled");
    clear(5'b00100, "R9 clear C");

    // R6: probe
    probe = 1; ep[3] = 1; go(3, "R6 probe rise no vector");
    probe = 0; go(3, "R6 probe fall ignored");
    clear(5'b01000, "R9 clear probe");

    // R7: keys
    keys = 8'hDF; ep[4] = 1; go(3, "R7 one key falls");
    clear(5'b10000, "R9 clear key");
    keys = 8'hFF; go(3, "R7 key rise ignored");
    keys = 8'h7E; ep[4] = 1; go(3, "R7 two keys fall");
    clear(5'b10000, "R9 clear key");
    keys = 8'hFF; waitn(4);

    // R3: filtered line A
    filt_en = 1; sel_a = 2'b00; line_a = 1;
    push(5, "R3 not yet accepted");
    ep[0] = 1; push(6, "R3 accepted on 6th edge");
    waitn(7);
    clear(5'b00001, "R9 clear A");
    line_a = 0; waitn(8);
    line_a = 1; waitn(2); line_a = 0;
    go(7, "R3 two-clock glitch rejected");

    // R4 / R2: bypass
    filt_en = 0; line_a = 1; waitn(1); line_a = 0;
    ep[0] = 1; push(2, "R4 one-clock pulse flagged");
    waitn(5);
    clear(5'b00001, "R9 clear A");
    sel_a = 2'b01; line_a = 1; go(3, "R2 rise ignored under fall code");
    line_a = 0; ep[0] = 1; go(3, "R2 fall code");
    clear(5'b00001, "R9 clear A");

    // R10: edge and clear on the same clock
    sel_b = 2'b00; line_b = 1; ep[1] = 1;
    push(3, "R10 set beats clear");
    waitn(2);
    clr_wr = 1; clr_mask = 5'b00010;
    waitn(1);
    clr_wr = 0; clr_mask = 0;
    waitn(2);
    clear(5'b00010, "R9 clear after collision");

    waitn(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule